// File: doc/BRIEF.md
# MIDI Host Port Controller

This block gives a host CPU a two-byte register window for sending and receiving MIDI bytes. Offset 0 is the data register for both reads and writes. Offset 1 returns status when read and takes a command when written. The usual base address for the window is 0x330; the decode of that base lies outside the block. Host accesses are single-cycle strobes. Read data is registered and appears on the cycle after the read strobe.

The controller comes out of reset in the command-only mode, state `MODE_SMART`. Writing command 0x3F in that state takes the transition `ENTER_UART` to state `MODE_UART`. In `MODE_UART`, data-port writes go out on a valid/ready transmit stream, and data-port reads pop bytes from a valid/ready receive stream. Command 0xFF takes the transition `SOFT_RESET` from either state back to `MODE_SMART`. It pulses a flush toward the MIDI side. Any other command in `MODE_SMART` takes the self-loop `ACK_ONLY`. Any other command in `MODE_UART` takes the self-loop `DROP` and is ignored. A single response slot holds the acknowledge byte 0xFE. A read of the data port serves that slot before any received MIDI byte.

Top module: `midi_port_ctrl`

## Requirements
- R1: After hardware reset the block is in `MODE_SMART` with no response pending. A status read then returns 0x80. `host_rdata` reads 0x00 until the first read. Hardware reset queues no acknowledge.
- R2: Command 0x3F written in `MODE_SMART` enters `MODE_UART` and queues the acknowledge byte 0xFE.
- R3: Command 0xFF in either mode returns to `MODE_SMART` and clears the response slot before queuing 0xFE. `midi_flush` is high in the cycle of the command write.
- R4: An unrecognised command in `MODE_SMART` is acknowledged with 0xFE. In `MODE_UART`, every command other than 0xFF is dropped, and this includes 0x3F. A dropped command queues nothing.
- R5: Status bit 6 is 1 only in `MODE_UART` while `tx_ready` is low. It is always 0 in `MODE_SMART`.
- R6: Status bit 7 is 0 when a response is pending, or when the block is in `MODE_UART` with `rx_valid` high. Otherwise bit 7 is 1. Status bits 5 to 0 always read 0.
- R7: A data-port read returns the pending response byte and clears the slot. With no response pending, a read in `MODE_UART` returns `rx_data` when `rx_valid` is high. When neither source has a byte, the read returns 0xFE.
- R8: `rx_ready` pulses only on a data-port read in `MODE_UART` with no response pending and `rx_valid` high. A status read never consumes a received byte.
- R9: A data-port write in `MODE_UART` drives `tx_valid` high with `tx_data` equal to the written byte in that same cycle. In `MODE_SMART`, `tx_valid` stays low.
- R10: The response slot holds one byte. A second acknowledge queued before the first is read leaves only one byte pending.
- R11: `host_rdata` changes only on the clock edge that samples `host_rd_en`. It holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_rd_en | input | 1 | Single-cycle read strobe |
| host_wr_en | input | 1 | Single-cycle write strobe |
| host_addr | input | 1 | Register offset: 0 data, 1 status/command |
| host_wdata | input | 8 | Write data or command byte |
| host_rdata | output | 8 | Registered read data, valid the cycle after `host_rd_en` |
| tx_valid | output | 1 | Outgoing MIDI byte valid |
| tx_data | output | 8 | Outgoing MIDI byte |
| tx_ready | input | 1 | Transmit side has free space |
| rx_valid | input | 1 | Receive side holds a byte |
| rx_data | input | 8 | Head byte of the receive side |
| rx_ready | output | 1 | Pop strobe for the receive side |
| midi_flush | output | 1 | One-cycle reset pulse toward the MIDI side |

## Verification
Some rules are checked by the assertions on every cycle. The state and response slot after 0x3F or 0xFF is one. `MODE_SMART` must keep the transmit stream quiet. A pop may happen only on a data read, and a status read must leave the slot alone. Read data must hold between strobes. Other behaviour needs the bench's scenarios, because it shows only over a sequence of accesses. One case is the ordering of the acknowledge ahead of a waiting receive byte. Others are the 0xFE default on an empty read, and a second acknowledge collapsing into one slot. The last is a hardware reset that leaves no acknowledge behind.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
    localparam int BYTE_W = 8;
    localparam int STS_TX_BUSY = 6;
    localparam int STS_RX_NONE = 7;
    localparam logic [BYTE_W-1:0] CMD_UART  = 8'h3F;
    localparam logic [BYTE_W-1:0] CMD_RESET = 8'hFF;
    localparam logic [BYTE_W-1:0] ACK_CODE  = 8'hFE;

    typedef enum logic {
        MODE_SMART = 1'b0,
        MODE_UART  = 1'b1
    } mode_e;
endpackage

// File: rtl/midi_cmd_fsm.sv
module midi_cmd_fsm
    import midi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              resp_take,
    output logic              uart_on,
    output logic              resp_pend,
    output logic              flush
);
    mode_e state, state_nx;
    logic  resp_set;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_SMART;
        else        state <= state_nx;
    end

    // Transitions and outputs
    always_comb begin
        state_nx = state;
        resp_set = 1'b0;
        flush    = 1'b0;
        if (cmd_we) begin
            unique case (state)
                MODE_SMART: begin
                    resp_set = 1'b1;                 // ACK_ONLY, ENTER_UART, SOFT_RESET
                    if (cmd_byte == CMD_RESET)     flush = 1'b1;
                    else if (cmd_byte == CMD_UART) state_nx = MODE_UART;
                end
                MODE_UART: begin
                    if (cmd_byte == CMD_RESET) begin  // SOFT_RESET; others DROP
                        flush    = 1'b1;
                        resp_set = 1'b1;
                        state_nx = MODE_SMART;
                    end
                end
                default: state_nx = MODE_SMART;
            endcase
        end
    end

    // Single response slot; a new acknowledge lands on top of an unread one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         resp_pend <= 1'b0;
        else if (resp_set)  resp_pend <= 1'b1;
        else if (resp_take) resp_pend <= 1'b0;
    end

    assign uart_on = (state == MODE_UART);

    p_uart_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && uart_on && cmd_byte != CMD_RESET && !resp_pend) |=> (!resp_pend && uart_on));
endmodule

// File: rtl/midi_rd_path.sv
module midi_rd_path
    import midi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              rd_addr,
    input  logic              uart_on,
    input  logic              resp_pend,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_ready,
    output logic              rx_pop,
    output logic              resp_take,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] status_byte, data_byte;
    logic              data_rd;

    assign data_rd   = rd_strobe && !rd_addr;
    assign resp_take = data_rd && resp_pend;
    assign rx_pop    = data_rd && uart_on && !resp_pend && rx_valid;

    always_comb begin
        status_byte = '0;
        status_byte[STS_TX_BUSY] = uart_on && !tx_ready;
        status_byte[STS_RX_NONE] = !(resp_pend || (uart_on && rx_valid));
    end

    always_comb begin
        if (resp_pend)                 data_byte = ACK_CODE;
        else if (uart_on && rx_valid)  data_byte = rx_data;
        else                           data_byte = ACK_CODE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata <= '0;
        else if (rd_strobe) rdata <= rd_addr ? status_byte : data_byte;
    end

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rdata));
endmodule

// File: rtl/midi_port_ctrl.sv
module midi_port_ctrl
    import midi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd_en,
    input  logic              host_wr_en,
    input  logic              host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              midi_flush
);
    logic uart_on, resp_pend, resp_take;

    midi_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (host_wr_en && host_addr),
        .cmd_byte  (host_wdata),
        .resp_take (resp_take),
        .uart_on   (uart_on),
        .resp_pend (resp_pend),
        .flush     (midi_flush)
    );

    midi_rd_path u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (host_rd_en),
        .rd_addr   (host_addr),
        .uart_on   (uart_on),
        .resp_pend (resp_pend),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_ready  (tx_ready),
        .rx_pop    (rx_ready),
        .resp_take (resp_take),
        .rdata     (host_rdata)
    );

    // Transmit path: data writes pass straight through in UART mode
    assign tx_valid = host_wr_en && !host_addr && uart_on;
    assign tx_data  = host_wdata;

    p_enter_uart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_addr && host_wdata == CMD_UART && !uart_on) |=> (uart_on && resp_pend));
    p_soft_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        midi_flush |=> (!uart_on && resp_pend));
    p_tx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_on |-> !tx_valid);
    p_pop_on_data_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (host_rd_en && !host_addr && rx_valid));
    p_status_keeps_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && host_addr && !host_wr_en) |=> $stable(resp_pend));
endmodule

// File: tb/midi_port_ctrl_tb_top.sv
module midi_port_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd_en = 1'b0, host_wr_en = 1'b0, host_addr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       tx_valid, rx_ready, midi_flush;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;
    logic       rx_valid;
    logic [7:0] rx_data;

    int tests = 0, fails = 0;
    logic [7:0] rxq [0:15];
    int rx_wr = 0, rx_rd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_valid = (rx_rd < rx_wr);
    assign rx_data  = rxq[rx_rd[3:0]];
    always @(posedge clk) if (rx_ready) rx_rd <= rx_rd + 1;

    midi_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_rd_en(host_rd_en), .host_wr_en(host_wr_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .midi_flush(midi_flush)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        @(negedge clk);
        host_rd_en = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic push_rx(logic [7:0] b);
        @(negedge clk);
        rxq[rx_wr[3:0]] = b;
        rx_wr = rx_wr + 1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rdata at reset", host_rdata, 8'h00);
        rd(1'b1, v); check("R1 status after reset", v, 8'h80);
        rd(1'b0, v); check("R7 empty read in smart mode", v, 8'hFE);
    endtask

    task automatic t_enter_uart();
        logic [7:0] v;
        wr(1'b1, 8'h3F);
        rd(1'b1, v); check("R2 R6 ack pending after 0x3F", v, 8'h00);
        rd(1'b0, v); check("R2 ack byte", v, 8'hFE);
        rd(1'b1, v); check("R6 uart status empty", v, 8'h80);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = 1'b0; host_wdata = 8'h90;
        #1;
        check("R9 tx_valid in uart", tx_valid, 1'b1);
        check("R9 tx_data in uart", tx_data, 8'h90);
        @(negedge clk); host_wr_en = 1'b0;
        tx_ready = 1'b0;
        rd(1'b1, v); check("R5 tx busy status", v, 8'hC0);
        tx_ready = 1'b1;
        rd(1'b1, v); check("R5 tx free status", v, 8'h80);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        int base;
        base = rx_rd;
        push_rx(8'h45); push_rx(8'h3C);
        rd(1'b1, v); check("R6 rx present status", v, 8'h00);
        rd(1'b1, v);
        check("R8 status read no pop", rx_rd - base, 0);
        rd(1'b0, v); check("R7 first rx byte", v, 8'h45);
        rd(1'b0, v); check("R7 second rx byte", v, 8'h3C);
        rd(1'b0, v); check("R7 empty uart read", v, 8'hFE);
        check("R8 pop count", rx_rd - base, 2);
    endtask

    task automatic t_uart_drop();
        logic [7:0] v;
        wr(1'b1, 8'h3F); wr(1'b1, 8'h12);
        rd(1'b1, v); check("R4 uart commands dropped", v, 8'h80);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = 1'b1; host_wdata = 8'hFF;
        #1; check("R3 flush pulse", midi_flush, 1'b1);
        @(negedge clk); host_wr_en = 1'b0;
        #1; check("R3 flush ends", midi_flush, 1'b0);
        tx_ready = 1'b0;
        rd(1'b1, v); check("R3 R5 smart with ack", v, 8'h00);
        tx_ready = 1'b1;
        rd(1'b0, v); check("R3 ack after reset", v, 8'hFE);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = 1'b0; host_wdata = 8'h55;
        #1; check("R9 smart write ignored", tx_valid, 1'b0);
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic t_priority();
        logic [7:0] v;
        int base;
        base = rx_rd;
        push_rx(8'h22);
        rd(1'b1, v); check("R6 rx ignored in smart", v, 8'h80);
        rd(1'b0, v); check("R7 smart read not rx", v, 8'hFE);
        check("R8 no pop in smart", rx_rd - base, 0);
        wr(1'b1, 8'h3F);
        rd(1'b0, v); check("R7 ack before rx", v, 8'hFE);
        check("R8 no pop while pending", rx_rd - base, 0);
        rd(1'b0, v); check("R7 rx after ack", v, 8'h22);
        wr(1'b1, 8'hFF);
        rd(1'b0, v);
    endtask

    task automatic t_overwrite();
        logic [7:0] v;
        wr(1'b1, 8'h12);
        rd(1'b1, v); check("R4 smart unknown acked", v, 8'h00);
        wr(1'b1, 8'h34);
        rd(1'b0, v); check("R10 single ack byte", v, 8'hFE);
        rd(1'b1, v); check("R10 slot empty after one read", v, 8'h80);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        wr(1'b1, 8'h3F);
        rd(1'b1, v);
        @(negedge clk);
        host_rd_en = 1'b1; host_addr = 1'b0;
        #1; check("R11 rdata before edge", host_rdata, 8'h00);
        @(negedge clk); host_rd_en = 1'b0;
        check("R11 rdata after edge", host_rdata, 8'hFE);
        repeat (3) @(negedge clk);
        check("R11 rdata held", host_rdata, 8'hFE);
    endtask

    task automatic t_hw_reset();
        logic [7:0] v;
        wr(1'b1, 8'hAA);
        do_reset();
        rd(1'b1, v); check("R1 hw reset no ack", v, 8'h80);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = 1'b0; host_wdata = 8'h77;
        #1; check("R1 hw reset leaves uart", tx_valid, 1'b0);
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enter_uart();
        t_tx();
        t_rx();
        t_uart_drop();
        t_soft_reset();
        t_priority();
        t_overwrite();
        t_hold();
        t_hw_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule